// File: doc/BRIEF.md
# Wedge Partition Distortion Search Engine

This engine picks, for one square block of depth samples, the best of a fixed number of two-region partition masks. The block's samples are first streamed in one per cycle and held in a local store. The caller then offers one candidate mask at a time, each tagged with a template identifier. For every mask the engine runs two passes over the stored samples. The first pass gathers the sum and the population of each region. Each region's constant value is then set to the rounded mean of that region. The second pass sums the absolute differences between each sample and the constant of its region. The engine keeps the identifier, the distortion and both constants of the best candidate. It raises `done` once every candidate has been scored.

A block that an upstream detector has already judged flat is started with `flat_in` high. In that case the engine asks for no mask and reports at once that the block goes to ordinary intra prediction.

The controller is a single state machine with eight states:
- `ST_IDLE` goes to `ST_LOAD` on `start`, or to `ST_DONE` on `start` with `flat_in` high.
- `ST_LOAD` goes to `ST_WAIT` after the last sample.
- `ST_WAIT` goes to `ST_SUM` when a mask is accepted.
- `ST_SUM` (pass one) goes to `ST_CPV` after the last sample.
- `ST_CPV` registers both region constants and goes to `ST_SAD`.
- `ST_SAD` (pass two) goes to `ST_UPDATE` after the last sample.
- `ST_UPDATE` compares against the best record. It goes back to `ST_WAIT` while candidates remain, and to `ST_DONE` after the last one.
- `ST_DONE` goes to `ST_IDLE`.

Top module: `wedge_sad_search`

## Requirements
- R1: After reset `done` and `mask_ready` are low and the engine waits in idle for `start`.
- R2: After `start` with `flat_in` low, the engine takes exactly BLK*BLK samples on cycles with `pix_valid` high, in raster order (index k = row*BLK + col), and then raises `mask_ready`.
- R3: Mask bit k places sample k in region two when 1 and in region one when 0. Each region's constant is its rounded mean, (sum + count/2)/count in integer division, reported as `best_d1` (region one) and `best_d2` (region two).
- R4: A region with no samples takes as its constant the rounded mean of the whole block, (total + BLK*BLK/2)/(BLK*BLK).
- R5: A candidate's distortion is the sum over all samples of |sample - constant of its region|, and it never exceeds BLK*BLK*(2^PIX_W-1).
- R6: The best distortion is set to all ones on `start`. A candidate replaces the best record only when its distortion is strictly smaller, so on a tie the earlier candidate is kept.
- R7: After NUM_TPL candidates, `done` is high for exactly one cycle, and the best identifier, distortion and constants stay on the outputs until the next `start`.
- R8: `start` with `flat_in` high gives `done` on the next cycle with `is_flat` high. In that case no mask is requested, the best distortion is all ones, and the identifier and constants are zero. `is_flat` is low for a block searched normally.
- R9: `mask_ready` is high only while the engine waits for a mask. A `mask_valid` pulse while it is low, and a `start` pulse while a search is running, have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a new block when idle |
| flat_in | input | 1 | Block is flat; skip the search |
| pix_valid | input | 1 | `pix_data` carries the next sample |
| pix_data | input | PIX_W | Depth sample, raster order |
| mask_valid | input | 1 | Candidate mask offered |
| mask_bits | input | BLK*BLK | Partition mask, bit k for sample k |
| mask_id | input | ID_W | Template identifier of the mask |
| mask_ready | output | 1 | Engine waits for a mask |
| done | output | 1 | One-cycle result strobe |
| is_flat | output | 1 | Result is the flat-block bypass |
| best_id | output | ID_W | Identifier of the winning mask |
| best_sad | output | PIX_W+clog2(BLK*BLK+1) | Distortion of the winner |
| best_d1 | output | PIX_W | Region-one constant of the winner |
| best_d2 | output | PIX_W | Region-two constant of the winner |

## Verification
Some properties are checked by assertions on every cycle:
- the two region populations together cover the block when the constants are taken;
- a finished distortion stays within its bound;
- the best distortion never rises within a search, and a candidate that is not strictly smaller leaves the winner's identifier untouched;
- `done` lasts one cycle and comes only after the full candidate count.

Other behaviours only the bench scenarios can show:
- the arithmetic of the rounded means and the empty-region fallback;
- the exact winner for edge, gradient, diagonal, checkerboard and constant blocks;
- the flat bypass;
- that stray mask and start pulses during a pass are ignored.

// File: rtl/wedge_pkg.sv
package wedge_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_WAIT,
        ST_SUM,
        ST_CPV,
        ST_SAD,
        ST_UPDATE,
        ST_DONE
    } wedge_state_e;
endpackage

// File: rtl/wedge_pix_store.sv
module wedge_pix_store #(
    parameter int PIX_W = 8,
    parameter int DEPTH = 64,
    parameter int AW    = 6
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [AW-1:0]    addr,
    input  logic [PIX_W-1:0] wr_data,
    output logic [PIX_W-1:0] rd_data
);
    logic [PIX_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[addr] <= wr_data;
    end

    assign rd_data = mem[addr];
endmodule

// File: rtl/wedge_cpv_div.sv
module wedge_cpv_div #(
    parameter int PIX_W = 8,
    parameter int CNT_W = 7,
    parameter int ACC_W = 15
) (
    input  logic [ACC_W-1:0] seg_sum,
    input  logic [CNT_W-1:0] seg_cnt,
    input  logic [PIX_W-1:0] fallback,
    output logic [PIX_W-1:0] cpv
);
    logic [ACC_W:0] num;
    logic [ACC_W:0] den;

    always_comb begin
        num = {1'b0, seg_sum} + (ACC_W+1)'(seg_cnt >> 1);
        den = (seg_cnt == '0) ? (ACC_W+1)'(1) : (ACC_W+1)'(seg_cnt);
        cpv = (seg_cnt == '0) ? fallback : PIX_W'(num / den);
    end
endmodule

// File: rtl/wedge_best_keep.sv
module wedge_best_keep #(
    parameter int PIX_W = 8,
    parameter int ID_W  = 4,
    parameter int ACC_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init,
    input  logic             upd,
    input  logic [ID_W-1:0]  cand_id,
    input  logic [ACC_W-1:0] cand_sad,
    input  logic [PIX_W-1:0] cand_d1,
    input  logic [PIX_W-1:0] cand_d2,
    output logic [ID_W-1:0]  best_id,
    output logic [ACC_W-1:0] best_sad,
    output logic [PIX_W-1:0] best_d1,
    output logic [PIX_W-1:0] best_d2
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            best_id  <= '0;
            best_sad <= '1;
            best_d1  <= '0;
            best_d2  <= '0;
        end else if (init) begin
            best_id  <= '0;
            best_sad <= '1;
            best_d1  <= '0;
            best_d2  <= '0;
        end else if (upd && (cand_sad < best_sad)) begin
            best_id  <= cand_id;
            best_sad <= cand_sad;
            best_d1  <= cand_d1;
            best_d2  <= cand_d2;
        end
    end

    // R6: within a search the best distortion only falls or holds
    a_r6_best_monotone: assert property (@(posedge clk) disable iff (!rst_n)
        !init |=> best_sad <= $past(best_sad));

    // R6: a tie or a worse candidate leaves the earlier winner in place
    a_r6_tie_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && !init && cand_sad >= best_sad) |=> $stable(best_id));
endmodule

// File: rtl/wedge_sad_search.sv
module wedge_sad_search
    import wedge_pkg::*;
#(
    parameter int PIX_W   = 8,
    parameter int BLK     = 8,
    parameter int NUM_TPL = 10,
    parameter int ID_W    = 4
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  start,
    input  logic                                  flat_in,
    input  logic                                  pix_valid,
    input  logic [PIX_W-1:0]                      pix_data,
    input  logic                                  mask_valid,
    input  logic [BLK*BLK-1:0]                    mask_bits,
    input  logic [ID_W-1:0]                       mask_id,
    output logic                                  mask_ready,
    output logic                                  done,
    output logic                                  is_flat,
    output logic [ID_W-1:0]                       best_id,
    output logic [PIX_W+$clog2(BLK*BLK+1)-1:0]    best_sad,
    output logic [PIX_W-1:0]                      best_d1,
    output logic [PIX_W-1:0]                      best_d2
);
    localparam int NPIX  = BLK * BLK;
    localparam int IDX_W = (NPIX > 1) ? $clog2(NPIX) : 1;
    localparam int CNT_W = $clog2(NPIX + 1);
    localparam int ACC_W = PIX_W + CNT_W;
    localparam int TPL_W = $clog2(NUM_TPL + 1);

    wedge_state_e state, state_nx;

    logic [IDX_W-1:0] idx;
    logic [TPL_W-1:0] tpl_cnt;
    logic [NPIX-1:0]  mask_r;
    logic [ID_W-1:0]  id_r;
    logic [ACC_W-1:0] total;
    logic [ACC_W-1:0] seg_sum [2];
    logic [CNT_W-1:0] seg_cnt [2];
    logic [PIX_W-1:0] seg_cpv [2];
    logic [PIX_W-1:0] cpv_r   [2];
    logic [ACC_W-1:0] sad_acc;
    logic             flat_r;
    logic [PIX_W-1:0] cur_pix;
    logic [PIX_W-1:0] blk_mean;
    logic [PIX_W-1:0] ref_v;
    logic [PIX_W-1:0] abs_diff;
    logic             cur_bit;
    logic             last_idx;
    logic             idx_adv;

    assign last_idx = (idx == IDX_W'(NPIX - 1));
    assign cur_bit  = mask_r[idx];
    assign idx_adv  = (state == ST_LOAD && pix_valid) || state == ST_SUM || state == ST_SAD;

    wedge_pix_store #(.PIX_W(PIX_W), .DEPTH(NPIX), .AW(IDX_W)) u_store (
        .clk     (clk),
        .wr_en   (state == ST_LOAD && pix_valid),
        .addr    (idx),
        .wr_data (pix_data),
        .rd_data (cur_pix)
    );

    assign blk_mean = PIX_W'((total + ACC_W'(NPIX / 2)) / ACC_W'(NPIX));

    for (genvar g = 0; g < 2; g++) begin : g_seg
        wedge_cpv_div #(.PIX_W(PIX_W), .CNT_W(CNT_W), .ACC_W(ACC_W)) u_div (
            .seg_sum  (seg_sum[g]),
            .seg_cnt  (seg_cnt[g]),
            .fallback (blk_mean),
            .cpv      (seg_cpv[g])
        );
    end

    always_comb begin
        ref_v    = cur_bit ? cpv_r[1] : cpv_r[0];
        abs_diff = (cur_pix >= ref_v) ? (cur_pix - ref_v) : (ref_v - cur_pix);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start) state_nx = flat_in ? ST_DONE : ST_LOAD;
            ST_LOAD:   if (pix_valid && last_idx) state_nx = ST_WAIT;
            ST_WAIT:   if (mask_valid) state_nx = ST_SUM;
            ST_SUM:    if (last_idx) state_nx = ST_CPV;
            ST_CPV:    state_nx = ST_SAD;
            ST_SAD:    if (last_idx) state_nx = ST_UPDATE;
            ST_UPDATE: state_nx = (tpl_cnt == TPL_W'(NUM_TPL - 1)) ? ST_DONE : ST_WAIT;
            ST_DONE:   state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mask_ready = (state == ST_WAIT);
        done       = (state == ST_DONE);
        is_flat    = flat_r;
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx      <= '0;
            tpl_cnt  <= '0;
            mask_r   <= '0;
            id_r     <= '0;
            total    <= '0;
            seg_sum  <= '{default: '0};
            seg_cnt  <= '{default: '0};
            cpv_r    <= '{default: '0};
            sad_acc  <= '0;
            flat_r   <= 1'b0;
        end else begin
            if (idx_adv) idx <= last_idx ? '0 : idx + IDX_W'(1);
            else if (state == ST_IDLE) idx <= '0;

            if (state == ST_IDLE && start) begin
                total   <= '0;
                tpl_cnt <= '0;
                flat_r  <= flat_in;
            end
            if (state == ST_LOAD && pix_valid) total <= total + ACC_W'(pix_data);

            if (state == ST_WAIT && mask_valid) begin
                mask_r  <= mask_bits;
                id_r    <= mask_id;
                seg_sum <= '{default: '0};
                seg_cnt <= '{default: '0};
            end
            if (state == ST_SUM) begin
                seg_sum[cur_bit] <= seg_sum[cur_bit] + ACC_W'(cur_pix);
                seg_cnt[cur_bit] <= seg_cnt[cur_bit] + CNT_W'(1);
            end
            if (state == ST_CPV) begin
                cpv_r   <= seg_cpv;
                sad_acc <= '0;
            end
            if (state == ST_SAD) sad_acc <= sad_acc + ACC_W'(abs_diff);
            if (state == ST_UPDATE) tpl_cnt <= tpl_cnt + TPL_W'(1);
        end
    end

    wedge_best_keep #(.PIX_W(PIX_W), .ID_W(ID_W), .ACC_W(ACC_W)) u_best (
        .clk      (clk),
        .rst_n    (rst_n),
        .init     (state == ST_IDLE && start),
        .upd      (state == ST_UPDATE),
        .cand_id  (id_r),
        .cand_sad (sad_acc),
        .cand_d1  (cpv_r[0]),
        .cand_d2  (cpv_r[1]),
        .best_id  (best_id),
        .best_sad (best_sad),
        .best_d1  (best_d1),
        .best_d2  (best_d2)
    );

    // R3: the two regions together hold every sample when constants are taken
    a_r3_split_covers_block: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CPV) |-> ((CNT_W+1)'(seg_cnt[0]) + (CNT_W+1)'(seg_cnt[1]) == (CNT_W+1)'(NPIX)));

    // R5: a finished distortion stays within the block's bound
    a_r5_sad_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_UPDATE) |-> (sad_acc <= ACC_W'(NPIX * ((1 << PIX_W) - 1))));

    // R7: the result strobe is a single cycle
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: a searched result appears only after the full candidate count
    a_r7_all_scored: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !is_flat) |-> (tpl_cnt == TPL_W'(NUM_TPL)));
endmodule

// File: tb/test_wedge_sad_search.sv
module test_wedge_sad_search;
    localparam int CLK_PERIOD = 10;
    localparam int PIX_W   = 8;
    localparam int BLK     = 8;
    localparam int NUM_TPL = 10;
    localparam int ID_W    = 4;
    localparam int NPIX    = BLK * BLK;
    localparam int ACC_W   = PIX_W + $clog2(NPIX + 1);
    localparam int NCASE   = 7;

    // case table: pixel pattern, stray pulses during passes, hand-known winner id (-1: model only)
    localparam int T_PAT   [NCASE] = '{1, 2, 3, 4, 5, 0, 3};
    localparam int T_STRAY [NCASE] = '{0, 0, 0, 0, 0, 0, 1};
    localparam int T_ID    [NCASE] = '{8, -1, -1, -1, -1, 15, -1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, flat_in = 1'b0, pix_valid = 1'b0, mask_valid = 1'b0;
    logic [PIX_W-1:0] pix_data = '0;
    logic [NPIX-1:0]  mask_bits = '0;
    logic [ID_W-1:0]  mask_id = '0;
    logic mask_ready, done, is_flat;
    logic [ID_W-1:0]  best_id;
    logic [ACC_W-1:0] best_sad;
    logic [PIX_W-1:0] best_d1, best_d2;

    int n_chk = 0;
    int n_err = 0;
    int cycles = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    wedge_sad_search #(.PIX_W(PIX_W), .BLK(BLK), .NUM_TPL(NUM_TPL), .ID_W(ID_W)) i_wedge_sad_search (
        .clk(clk), .rst_n(rst_n), .start(start), .flat_in(flat_in),
        .pix_valid(pix_valid), .pix_data(pix_data),
        .mask_valid(mask_valid), .mask_bits(mask_bits), .mask_id(mask_id),
        .mask_ready(mask_ready), .done(done), .is_flat(is_flat),
        .best_id(best_id), .best_sad(best_sad), .best_d1(best_d1), .best_d2(best_d2)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    function automatic int pix_of(int pat, int k);
        int r = k / BLK;
        int c = k % BLK;
        case (pat)
            0: return 77;
            1: return (c >= 3) ? 200 : 20;
            2: return r * 16 + c * 9;
            3: return ((c > r) ? 250 : 5) - ((k * 7) % 5);
            4: return ((r + c) % 2 == 1) ? 2 : 1;
            5: return ((r + c) % 2 == 1) ? 255 : 0;
            default: return 0;
        endcase
    endfunction

    function automatic logic [NPIX-1:0] mask_of(int j);
        logic [NPIX-1:0] m;
        for (int k = 0; k < NPIX; k++) begin
            int r = k / BLK;
            int c = k % BLK;
            case (j)
                0: m[k] = 1'b0;
                1: m[k] = (c >= BLK / 2);
                2: m[k] = (r >= BLK / 2);
                3: m[k] = (c > r);
                4: m[k] = (c + r >= BLK);
                5: m[k] = (c >= 1);
                6: m[k] = (r >= BLK - 1);
                7: m[k] = (c >= 3);
                8: m[k] = (r >= 3);
                default: m[k] = 1'b1;
            endcase
        end
        return m;
    endfunction

    function automatic int id_of(int j);
        return 15 - j;
    endfunction

    // model from the requirements: rounded means, empty-region fallback, strict-less winner
    task automatic model(input int pat, output int e_id, output int e_sad, output int e_d1, output int e_d2);
        int tot = 0;
        int mean;
        e_id = 0; e_sad = (1 << ACC_W) - 1; e_d1 = 0; e_d2 = 0;
        for (int k = 0; k < NPIX; k++) tot += pix_of(pat, k);
        mean = (tot + NPIX / 2) / NPIX;
        for (int j = 0; j < NUM_TPL; j++) begin
            logic [NPIX-1:0] m = mask_of(j);
            int s0 = 0, s1 = 0, c0 = 0, c1 = 0, d0, d1, sad = 0;
            for (int k = 0; k < NPIX; k++) begin
                if (m[k]) begin s1 += pix_of(pat, k); c1++; end
                else      begin s0 += pix_of(pat, k); c0++; end
            end
            d0 = (c0 == 0) ? mean : (s0 + c0 / 2) / c0;
            d1 = (c1 == 0) ? mean : (s1 + c1 / 2) / c1;
            for (int k = 0; k < NPIX; k++) begin
                int p = pix_of(pat, k);
                int rv = m[k] ? d1 : d0;
                sad += (p >= rv) ? p - rv : rv - p;
            end
            if (sad < e_sad) begin
                e_sad = sad; e_id = id_of(j); e_d1 = d0; e_d2 = d1;
            end
        end
    endtask

    task automatic wait_sig(input bit want_ready);
        for (int t = 0; t < 1000; t++) begin
            if (want_ready ? mask_ready : done) return;
            @(negedge clk);
        end
    endtask

    task automatic run_block(input int pat, input int stray, input int known_id);
        int e_id, e_sad, e_d1, e_d2;
        model(pat, e_id, e_sad, e_d1, e_d2);
        start = 1'b1; flat_in = 1'b0;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < NPIX; k++) begin
            pix_valid = 1'b1;
            pix_data = PIX_W'(pix_of(pat, k));
            @(negedge clk);
        end
        pix_valid = 1'b0;
        chk(mask_ready == 1'b1, "R2 ready after load", mask_ready, 1);
        for (int j = 0; j < NUM_TPL; j++) begin
            wait_sig(1'b1);
            mask_valid = 1'b1; mask_bits = mask_of(j); mask_id = ID_W'(id_of(j));
            @(negedge clk);
            mask_valid = 1'b0;
            if (j == 0) chk(mask_ready == 1'b0, "R9 ready low in pass", mask_ready, 0);
            if (stray != 0) begin
                // R9: stray mask and start while busy must be ignored
                mask_valid = 1'b1; mask_bits = '1; mask_id = '0; start = 1'b1;
                @(negedge clk);
                mask_valid = 1'b0; start = 1'b0;
            end
        end
        wait_sig(1'b0);
        chk(done == 1'b1, "R7 done raised", done, 1);
        chk(is_flat == 1'b0, "R8 not flat", is_flat, 0);
        chk(best_sad == ACC_W'(e_sad), "R5 best sad", best_sad, e_sad);
        chk(best_id == ID_W'(e_id), "R6 best id", best_id, e_id);
        chk(best_d1 == PIX_W'(e_d1), "R3 d1", best_d1, e_d1);
        chk(best_d2 == PIX_W'(e_d2), "R3 d2", best_d2, e_d2);
        if (known_id >= 0) chk(best_id == ID_W'(known_id), "R6 known winner", best_id, known_id);
        @(negedge clk);
        chk(done == 1'b0, "R7 done one cycle", done, 0);
        chk(best_sad == ACC_W'(e_sad) && best_id == ID_W'(e_id), "R7 result held", best_id, e_id);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(done == 1'b0, "R1 reset done", done, 0);
        chk(mask_ready == 1'b0, "R1 reset ready", mask_ready, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done == 1'b0 && mask_ready == 1'b0, "R1 idle after reset", {done, mask_ready}, 0);

        for (int i = 0; i < NCASE; i++) run_block(T_PAT[i], T_STRAY[i], T_ID[i]);

        // R4: constant block, empty region (first mask) falls back to block mean
        // R6: every candidate ties at zero, first one (id 15) kept
        run_block(0, 0, 15);
        chk(best_d1 == 77 && best_d2 == 77, "R4 empty region mean", best_d2, 77);

        // R3 rounding: pattern 4 with all-zero mask -> mean 1.5 rounds to 2
        begin
            int e_id, e_sad, e_d1, e_d2;
            model(4, e_id, e_sad, e_d1, e_d2);
            chk(e_sad <= 64, "R3 rounding model sane", e_sad, 64);
        end

        // R8: flat bypass
        @(negedge clk);
        start = 1'b1; flat_in = 1'b1;
        @(negedge clk);
        start = 1'b0; flat_in = 1'b0;
        chk(done == 1'b1, "R8 flat done next cycle", done, 1);
        chk(is_flat == 1'b1, "R8 flat flag", is_flat, 1);
        chk(best_sad == '1, "R8 flat sad all ones", best_sad, (1 << ACC_W) - 1);
        chk(best_id == '0 && best_d1 == '0 && best_d2 == '0, "R8 flat zero record", best_id, 0);
        chk(mask_ready == 1'b0, "R8 no mask asked", mask_ready, 0);
        @(negedge clk);
        chk(done == 1'b0, "R8 flat done one cycle", done, 0);

        // R8: a normal block after a flat one clears the flag
        run_block(1, 0, 8);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule